// File: doc/BRIEF.md
# One-Wire Slave ROM Command Responder

This block is the ROM-function layer of a one-wire slave device. A time-slot front end hands it one event per cycle: a decoded write-slot bit, a read-slot request, or a bus-reset indication. The block turns these into command bytes, holds a fixed identity code, and decides what the slave puts on the line in every read slot. The line is open-drain, so a released line reads as 1 and the slave can only pull it to 0.

Two ROM commands are recognised. The skip command opens the memory layer at once, with no identity exchange. The search command runs bitwise arbitration over the identity code. For each code bit, the block first answers a read with the bit, then answers a read with its complement, and then compares the master's written choice with its own bit. On a mismatch it leaves the search. When the last bit matches, it is selected and opens the memory layer. Any other command byte parks the slave until the next bus reset.

Top module: `owr_rom_responder`

## Requirements
- R1: After power-on reset or a bus reset, the block waits for a command byte. In that state `mem_access_o` is 0, `rd_bit_o` is 1, and read requests change nothing.
- R2: A command byte is built from eight consecutive accepted write bits, least significant bit first. Only writes received while waiting for a command count.
- R3: Command byte 0xCC sets `mem_access_o` to 1 from the cycle after the eighth bit. It stays 1, with `rd_bit_o` at 1, until a bus reset.
- R4: Command byte 0xF0 starts a search at bit 0 of `ID_CODE`, so the first search read returns `ID_CODE[0]`.
- R5: Each search bit takes three steps. The first read returns the code bit, the second read returns its complement, and the next write is compared with the code bit. `rd_bit_o` shows the pending answer, and a read request consumes it.
- R6: During a search, a write that arrives before both reads of the current bit is ignored. A read that arrives while the write is awaited returns 1 and does not advance.
- R7: A written bit equal to the code bit moves the search to the next code bit. A written bit that differs drops the slave out: every later read returns 1 and writes are ignored until a bus reset.
- R8: When the written bit for the last code bit matches, `mem_access_o` becomes 1 in the next cycle.
- R9: Any command byte other than 0xCC or 0xF0 parks the slave. Reads return 1, `mem_access_o` stays 0, and later writes form no command until a bus reset.
- R10: A bus reset aborts any command in any state and returns to waiting for a command. It takes priority over a write in the same cycle.
- R11: `rd_bit_o` is 0 only while the slave is in a search and answering with a 0 code bit or a 0 complement bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: a bus reset was seen on the line |
| wr_valid_i | input | 1 | One-cycle pulse: a write slot delivered a bit |
| wr_bit_i | input | 1 | Value of the delivered write bit |
| rd_req_i | input | 1 | One-cycle pulse: a read slot is consuming `rd_bit_o` |
| rd_bit_o | output | 1 | Bit for the current read slot (1 = release the line) |
| mem_access_o | output | 1 | The memory layer may run |

## Verification
Some rules are checked on every cycle. A bus reset always leads back to the quiet waiting state. The line is only ever pulled low during a search. The complement read is the exact inverse of the bit read just before it. A mismatching write always parks the slave. Once memory access or the parked state has been entered, it holds until a bus reset.

Other behaviour only the bench's scenarios can show. These are the byte assembly order, and which command codes open which path. They also include a full 64-bit search that ends in selection, a dropout partway through the code, slots that arrive out of order, and a bus reset that collides with the eighth command bit.

// File: rtl/owr_pkg.sv
package owr_pkg;

   // ROM layer control states
   typedef enum logic [1:0] {
      ROM_WAIT_CMD  = 2'd0,
      ROM_MEM_OPEN  = 2'd1,
      ROM_SEARCHING = 2'd2,
      ROM_PARKED    = 2'd3
   } rom_state_t;

   // Steps within one search bit
   typedef enum logic [1:0] {
      SPH_TRUE  = 2'd0,
      SPH_COMP  = 2'd1,
      SPH_WRITE = 2'd2
   } srch_phase_t;

endpackage

// File: rtl/owr_cmd_collect.sv
// Assembles a command word from serial write bits, LSB first.
module owr_cmd_collect #(
   parameter int CMD_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr_i,
   input  logic                shift_i,
   input  logic                bit_i,
   output logic                done_o,
   output logic [CMD_BITS-1:0] byte_o
);
   localparam int CW = (CMD_BITS > 1) ? $clog2(CMD_BITS) : 1;
   localparam logic [CW-1:0] LAST = CW'(CMD_BITS - 1);

   generate
      if (CMD_BITS < 1) begin : g_bad_width
         $error("owr_cmd_collect: CMD_BITS must be at least 1");
      end
   endgenerate

   logic [CMD_BITS-1:0] sr_q;
   logic [CW-1:0]       cnt_q;

   // The newest bit enters at the top, so the first bit received ends at bit 0
   generate
      if (CMD_BITS == 1) begin : g_single
         assign byte_o = bit_i;
      end else begin : g_multi
         assign byte_o = {bit_i, sr_q[CMD_BITS-1:1]};
      end
   endgenerate

   assign done_o = shift_i && !clr_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (clr_i) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (shift_i) begin
         sr_q  <= byte_o;
         cnt_q <= done_o ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/owr_search_seq.sv
// Per-bit search sequencing: true bit, complement, then master's choice.
module owr_search_seq
   import owr_pkg::*;
#(
   parameter int                ID_BITS   = 64,
   parameter logic [ID_BITS-1:0] ID_CODE  = '0,
   parameter bit                LSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        rd_req_i,
   input  logic        wr_valid_i,
   input  logic        wr_bit_i,
   output logic        tx_bit_o,
   output logic        lose_o,
   output logic        win_o,
   output srch_phase_t phase_o
);
   localparam int IW = (ID_BITS > 1) ? $clog2(ID_BITS) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(ID_BITS - 1);

   generate
      if (ID_BITS < 2) begin : g_bad_len
         $error("owr_search_seq: ID_BITS must be at least 2");
      end
   endgenerate

   logic [IW-1:0] idx_q;
   srch_phase_t   phase_q;
   logic          code_bit;
   logic          wr_hit;

   // Bit order of the identity walk is a build-time option
   generate
      if (LSB_FIRST) begin : g_lsb
         assign code_bit = ID_CODE[idx_q];
      end else begin : g_msb
         assign code_bit = ID_CODE[LAST_IDX - idx_q];
      end
   endgenerate

   always_comb begin
      case (phase_q)
         SPH_TRUE: tx_bit_o = code_bit;
         SPH_COMP: tx_bit_o = ~code_bit;
         default:  tx_bit_o = 1'b1;
      endcase
   end

   assign wr_hit  = wr_valid_i && !clr_i && (phase_q == SPH_WRITE);
   assign lose_o  = wr_hit && (wr_bit_i != code_bit);
   assign win_o   = wr_hit && (wr_bit_i == code_bit) && (idx_q == LAST_IDX);
   assign phase_o = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         phase_q <= SPH_TRUE;
      end else if (clr_i) begin
         idx_q   <= '0;
         phase_q <= SPH_TRUE;
      end else begin
         case (phase_q)
            SPH_TRUE:  if (rd_req_i) phase_q <= SPH_COMP;
            SPH_COMP:  if (rd_req_i) phase_q <= SPH_WRITE;
            SPH_WRITE: if (wr_valid_i) begin
               phase_q <= SPH_TRUE;
               if (!lose_o && !win_o) idx_q <= idx_q + 1'b1;
            end
            default:   phase_q <= SPH_TRUE;
         endcase
      end
   end

endmodule

// File: rtl/owr_rom_ctrl.sv
// ROM command state machine.
module owr_rom_ctrl
   import owr_pkg::*;
#(
   parameter int                  CMD_BITS   = 8,
   parameter logic [CMD_BITS-1:0] SKIP_CMD   = 8'hCC,
   parameter logic [CMD_BITS-1:0] SEARCH_CMD = 8'hF0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_reset_i,
   input  logic                cmd_done_i,
   input  logic [CMD_BITS-1:0] cmd_byte_i,
   input  logic                lose_i,
   input  logic                win_i,
   output rom_state_t          state_o
);
   rom_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (bus_reset_i) begin
         state_d = ROM_WAIT_CMD;
      end else begin
         case (state_q)
            ROM_WAIT_CMD: if (cmd_done_i) begin
               if (cmd_byte_i == SKIP_CMD)        state_d = ROM_MEM_OPEN;
               else if (cmd_byte_i == SEARCH_CMD) state_d = ROM_SEARCHING;
               else                               state_d = ROM_PARKED;
            end
            ROM_SEARCHING: begin
               if (lose_i)     state_d = ROM_PARKED;
               else if (win_i) state_d = ROM_MEM_OPEN;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ROM_WAIT_CMD;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/owr_rom_responder.sv
module owr_rom_responder
   import owr_pkg::*;
#(
   parameter int                  ID_BITS      = 64,
   parameter logic [ID_BITS-1:0]  ID_CODE      = 64'hA5C3_0F96_1E2D_4B7A,
   parameter bit                  ID_LSB_FIRST = 1'b1,
   parameter int                  CMD_BITS     = 8,
   parameter logic [CMD_BITS-1:0] SKIP_CMD     = 8'hCC,
   parameter logic [CMD_BITS-1:0] SEARCH_CMD   = 8'hF0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_reset_i,
   input  logic wr_valid_i,
   input  logic wr_bit_i,
   input  logic rd_req_i,
   output logic rd_bit_o,
   output logic mem_access_o
);
   generate
      if (SKIP_CMD == SEARCH_CMD) begin : g_bad_codes
         $error("owr_rom_responder: command codes must differ");
      end
   endgenerate

   rom_state_t          rom_state;
   srch_phase_t         srch_phase;
   logic                cmd_done;
   logic [CMD_BITS-1:0] cmd_byte;
   logic                srch_tx;
   logic                srch_lose;
   logic                srch_win;
   logic                srch_clr;

   owr_cmd_collect #(.CMD_BITS(CMD_BITS)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (bus_reset_i),
      .shift_i (wr_valid_i && (rom_state == ROM_WAIT_CMD)),
      .bit_i   (wr_bit_i),
      .done_o  (cmd_done),
      .byte_o  (cmd_byte)
   );

   assign srch_clr = bus_reset_i || (rom_state != ROM_SEARCHING);

   owr_search_seq #(
      .ID_BITS   (ID_BITS),
      .ID_CODE   (ID_CODE),
      .LSB_FIRST (ID_LSB_FIRST)
   ) u_srch (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (srch_clr),
      .rd_req_i   (rd_req_i),
      .wr_valid_i (wr_valid_i),
      .wr_bit_i   (wr_bit_i),
      .tx_bit_o   (srch_tx),
      .lose_o     (srch_lose),
      .win_o      (srch_win),
      .phase_o    (srch_phase)
   );

   owr_rom_ctrl #(
      .CMD_BITS   (CMD_BITS),
      .SKIP_CMD   (SKIP_CMD),
      .SEARCH_CMD (SEARCH_CMD)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_reset_i (bus_reset_i),
      .cmd_done_i  (cmd_done),
      .cmd_byte_i  (cmd_byte),
      .lose_i      (srch_lose),
      .win_i       (srch_win),
      .state_o     (rom_state)
   );

   // Open-drain: outside a search the ROM layer always releases the line
   assign rd_bit_o     = (rom_state == ROM_SEARCHING) ? srch_tx : 1'b1;
   assign mem_access_o = (rom_state == ROM_MEM_OPEN);

endmodule

// File: rtl/owr_rom_checker.sv
module owr_rom_checker
   import owr_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        bus_reset_i,
   input logic        wr_valid_i,
   input logic        wr_bit_i,
   input logic        rd_req_i,
   input logic        rd_bit_o,
   input logic        mem_access_o,
   input rom_state_t  state_i,
   input srch_phase_t phase_i
);
   logic sent_bit_q;
   logic in_srch;

   assign in_srch = (state_i == ROM_SEARCHING);

   // The true bit the slave answered for the current search step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sent_bit_q <= 1'b1;
      else if (in_srch && phase_i == SPH_TRUE && rd_req_i) sent_bit_q <= rd_bit_o;
   end

   assert_wait_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ROM_WAIT_CMD) |-> (rd_bit_o && !mem_access_o));

   assert_access_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_access_o && !bus_reset_i) |=> mem_access_o);

   assert_comp_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_srch && phase_i == SPH_TRUE && rd_req_i && !bus_reset_i)
      |=> (phase_i == SPH_COMP && rd_bit_o == !$past(rd_bit_o)));

   assert_mismatch_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_srch && phase_i == SPH_WRITE && wr_valid_i && !bus_reset_i
       && wr_bit_i != sent_bit_q) |=> (state_i == ROM_PARKED));

   assert_access_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_access_o) |-> $past(wr_valid_i));

   assert_parked_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ROM_PARKED && !bus_reset_i) |=> (state_i == ROM_PARKED && rd_bit_o));

   assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset_i |=> (state_i == ROM_WAIT_CMD && !mem_access_o && rd_bit_o));

   assert_open_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_bit_o |-> in_srch);

endmodule

bind owr_rom_responder owr_rom_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_reset_i  (bus_reset_i),
   .wr_valid_i   (wr_valid_i),
   .wr_bit_i     (wr_bit_i),
   .rd_req_i     (rd_req_i),
   .rd_bit_o     (rd_bit_o),
   .mem_access_o (mem_access_o),
   .state_i      (rom_state),
   .phase_i      (srch_phase)
);

// File: tb/owr_rom_responder_bench.sv
module owr_rom_responder_bench;
   localparam logic [63:0] ID = 64'hA5C3_0F96_1E2D_4B7A;
   localparam int NVEC = 5;
   // {command byte, expected mem access, expected first read}
   localparam logic [9:0] VEC [NVEC] = '{
      {8'hCC, 1'b1, 1'b1},
      {8'hF0, 1'b0, ID[0]},
      {8'h0F, 1'b0, 1'b1},
      {8'h33, 1'b0, 1'b1},
      {8'hCD, 1'b0, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_reset = 1'b0;
   logic wr_valid = 1'b0;
   logic wr_bit = 1'b0;
   logic rd_req = 1'b0;
   logic rd_bit_o, mem_access_o;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   owr_rom_responder #(.ID_CODE(ID)) u_owr_rom_responder (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_reset_i  (bus_reset),
      .wr_valid_i   (wr_valid),
      .wr_bit_i     (wr_bit),
      .rd_req_i     (rd_req),
      .rd_bit_o     (rd_bit_o),
      .mem_access_o (mem_access_o)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk); wr_valid = 1'b1; wr_bit = b;
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic read_bit(output logic b);
      @(negedge clk); b = rd_bit_o; rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
   endtask

   task automatic pulse_reset();
      @(negedge clk); bus_reset = 1'b1;
      @(negedge clk); bus_reset = 1'b0;
   endtask

   initial begin
      logic r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset; a read changes nothing
      check("R1 mem after reset", mem_access_o, 1'b0);
      read_bit(r);
      check("R1 read while waiting", r, 1'b1);
      send_byte(8'hCC);
      check("R1 command still accepted after read", mem_access_o, 1'b1);

      // Table walk: R2 LSB-first assembly, R3 skip, R4 search start, R9 unknown
      for (int v = 0; v < NVEC; v++) begin
         pulse_reset();
         send_byte(VEC[v][9:2]);
         check($sformatf("R2/R3/R9 mem after cmd %h", VEC[v][9:2]), mem_access_o, VEC[v][1]);
         read_bit(r);
         check($sformatf("R4/R9 first read after cmd %h", VEC[v][9:2]), r, VEC[v][0]);
      end

      // R5, R8: complete search, all bits matched
      pulse_reset();
      send_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
         read_bit(r); check($sformatf("R5 true bit %0d", i), r, ID[i]);
         read_bit(r); check($sformatf("R5 comp bit %0d", i), r, ~ID[i]);
         if (i < 63) check("R8 no early access", mem_access_o, 1'b0);
         send_bit(ID[i]);
      end
      check("R8 selected after last bit", mem_access_o, 1'b1);

      // R7: dropout at bit 5
      pulse_reset();
      send_byte(8'hF0);
      for (int i = 0; i < 5; i++) begin
         read_bit(r); read_bit(r); send_bit(ID[i]);
      end
      read_bit(r); check("R7 bit5 before dropout", r, ID[5]);
      read_bit(r);
      send_bit(~ID[5]);
      read_bit(r); check("R7 released after loss", r, 1'b1);
      read_bit(r); check("R7 still released", r, 1'b1);
      send_bit(ID[6]);
      read_bit(r); check("R7 writes ignored after loss", r, 1'b1);
      check("R7 no access after loss", mem_access_o, 1'b0);

      // R6: out-of-order slots
      pulse_reset();
      send_byte(8'hF0);
      send_bit(ID[0]);
      read_bit(r); check("R6 early write ignored", r, ID[0]);
      read_bit(r); check("R6 complement", r, ~ID[0]);
      read_bit(r); check("R6 read while awaiting write", r, 1'b1);
      send_bit(ID[0]);
      read_bit(r); check("R6/R7 advanced to bit1", r, ID[1]);

      // R9: parked slave ignores a later skip
      pulse_reset();
      send_byte(8'h55);
      send_byte(8'hCC);
      check("R9 parked ignores skip", mem_access_o, 1'b0);

      // R10: reset mid-search, then skip works
      pulse_reset();
      send_byte(8'hF0);
      read_bit(r);
      pulse_reset();
      read_bit(r); check("R10 released after abort", r, 1'b1);
      send_byte(8'hCC);
      check("R10 skip after abort", mem_access_o, 1'b1);

      // R10: reset beats the eighth command bit
      pulse_reset();
      for (int i = 0; i < 7; i++) send_bit(1'(8'hCC >> i));
      @(negedge clk); bus_reset = 1'b1; wr_valid = 1'b1; wr_bit = 1'b1;
      @(negedge clk); bus_reset = 1'b0; wr_valid = 1'b0;
      check("R10 reset wins over write", mem_access_o, 1'b0);
      send_byte(8'hCC);
      check("R10 fresh byte after collision", mem_access_o, 1'b1);
      // R3/R11: access holds through writes; line released
      send_bit(1'b0);
      read_bit(r); check("R11 released in memory state", r, 1'b1);
      check("R3 access sticky", mem_access_o, 1'b1);
      pulse_reset();
      check("R3 access cleared by bus reset", mem_access_o, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule